// File: doc/BRIEF.md
# Paged NIC Control Register File

This block is the byte-wide host register interface of a small Ethernet controller. A host reaches it through a 4-bit offset and an 8-bit data bus, with separate read and write strobes. Offset 0 always holds the command register. The two top bits of the command register pick one of three register pages, and that page sets the meaning of offsets 1 to 15. Several offsets hold one register when read and a different one when written.

The block stores the ring-buffer page pointers, the transmit page and length, the remote-DMA address and length, the receive and data configuration bytes, the six station address bytes and the eight multicast filter bytes. It presents all of these on flat output buses to the receive, transmit and DMA engines. It also holds the interrupt status and mask registers and drives one level-sensitive interrupt line. The engines report events on a 7-bit event bus, and each bit sets the matching status bit. The block does not send frames and has no buffer memory.

Top module: `nic_page_regs`

## Requirements
- R1: A write to offset 0 always loads the command register, and a read of offset 0 returns it. For offsets 1 to 15, the page is command bits [7:6]: 0, 1 or 2. On page 3, writes change nothing and reads return 0x00.
- R2: A page-0 write to offset 7 clears each status bit in positions 0 to 6 whose data bit is 1. Status bit 7 is not affected. `irq` is high exactly when any of status bits 0 to 6 is set together with the same mask bit. Status bit 7 never raises `irq`.
- R3: After reset, status reads 0x80, the interrupt mask is zero and every other register is zero. A command write with bit 0 clear clears status bit 7. A command write with bit 0 set leaves status bit 7 unchanged.
- R4: A command write with bit 0 clear, with bit 3 or bit 4 set, and with a remote-DMA length of zero sets status bit 6. With a non-zero length, the same write leaves bit 6 clear.
- R5: A command write with bit 0 clear and bit 2 set does three things: it sets the transmit status (page 0, offset 4, read) to 0x01, it sets status bit 1, and it stores the command with bit 2 cleared. With bit 0 set, bit 2 is stored as written and nothing else happens.
- R6: Page-0 writes to offsets 1 and 2 set the ring start and stop pages. Page-2 reads of offsets 1 and 2 return them. Page-0 reads of offsets 1 and 2 return 0x00. Page-0 offset 3 is the boundary page for both read and write.
- R7: Page-1 offsets 1 to 6 hold the station address, offset 7 the current page, and offsets 8 to 15 the multicast filter. All of them can be written and read back. `station_addr[7:0]` is offset 1, and `mcast_filter[7:0]` is offset 8, each rising by one byte per offset.
- R8: On page 0, the transmit length is written at offsets 5 (low byte) and 6 (high byte). The remote-DMA address is at offsets 8 and 9, and can also be read there. The remote-DMA length is written at offsets 10 and 11. Writing one half of a 16-bit value leaves the other half unchanged.
- R9: Page-0 reads of offset 10 return 0x50 and of offset 11 return 0x43. Page-0 reads of offsets 12 to 15 return 0x00.
- R10: Bit k of `ev_set` sets status bit k, for k from 0 to 6. When a host clear and an event hit the same bit in the same cycle, the bit ends up set.
- R11: `host_rdata` is loaded on a clock edge where `host_rd` is high, and holds the state from before any write on that same edge. It holds its value while `host_rd` is low.
- R12: Page-0 writes to offsets 4, 12, 14 and 15 load the transmit page, the receive configuration, the data configuration and the interrupt mask (bits 6:0). These values appear on their output ports. They cannot be read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 4 | Register offset |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered host read data |
| ev_set | input | 7 | Engine event bits, one per status bit 0 to 6 |
| irq | output | 1 | Level interrupt |
| cmd_value | output | 8 | Stored command register |
| ring_start | output | 8 | Ring start page |
| ring_stop | output | 8 | Ring stop page |
| ring_bound | output | 8 | Boundary page |
| ring_cur | output | 8 | Current receive page |
| tx_page | output | 8 | Transmit start page |
| tx_len | output | 16 | Transmit length |
| dma_addr | output | 16 | Remote-DMA start address |
| dma_len | output | 16 | Remote-DMA length |
| rx_cfg | output | 8 | Receive configuration |
| data_cfg | output | 8 | Data configuration |
| station_addr | output | 48 | Station address, offset 1 in the low byte |
| mcast_filter | output | 64 | Multicast filter, offset 8 in the low byte |

## Verification
The hardest case to reach is a cycle in which a host clear of the status register and an engine event fall on the same bit. Only that cycle shows which of the two wins. The stimulus drives the event bus and the offset-7 write strobe on the same falling edge, so both reach the same rising edge. It does this once as a directed case and then many times with random event and clear patterns, each checked against a bench model of the status byte. Side effects of command writes depend on the state of other registers: the zero-length DMA completion depends on the length bytes, and the transmit self-clear depends on the stop bit. They are therefore reached by directed sequences that first set the length bytes and then issue the command.

// File: rtl/nic_regs_pkg.sv
// Package: shared constants and types for the paged NIC register file.
// Assumes byte-wide host data and a 4-bit offset space.
package nic_regs_pkg;
    localparam int BYTE_W  = 8;
    localparam int OFF_W   = 4;
    localparam int IRQ_SRC = 7;

    typedef enum logic [1:0] {
        PG_0 = 2'd0,
        PG_1 = 2'd1,
        PG_2 = 2'd2,
        PG_3 = 2'd3
    } page_e;

    // Offsets that carry behaviour
    localparam logic [OFF_W-1:0] OFF_CMD     = 4'd0;
    localparam logic [OFF_W-1:0] OFF_RING_LO = 4'd1;
    localparam logic [OFF_W-1:0] OFF_RING_HI = 4'd2;
    localparam logic [OFF_W-1:0] OFF_BOUND   = 4'd3;
    localparam logic [OFF_W-1:0] OFF_TX_PAGE = 4'd4;
    localparam logic [OFF_W-1:0] OFF_TXLEN_L = 4'd5;
    localparam logic [OFF_W-1:0] OFF_TXLEN_H = 4'd6;
    localparam logic [OFF_W-1:0] OFF_STATUS  = 4'd7;
    localparam logic [OFF_W-1:0] OFF_DADDR_L = 4'd8;
    localparam logic [OFF_W-1:0] OFF_DADDR_H = 4'd9;
    localparam logic [OFF_W-1:0] OFF_DLEN_L  = 4'd10;
    localparam logic [OFF_W-1:0] OFF_DLEN_H  = 4'd11;
    localparam logic [OFF_W-1:0] OFF_RXCFG   = 4'd12;
    localparam logic [OFF_W-1:0] OFF_DCFG    = 4'd14;
    localparam logic [OFF_W-1:0] OFF_MASK    = 4'd15;
    localparam logic [OFF_W-1:0] OFF_STA     = 4'd1;
    localparam logic [OFF_W-1:0] OFF_CUR     = 4'd7;
    localparam logic [OFF_W-1:0] OFF_MC      = 4'd8;

    // Fixed read values
    localparam logic [BYTE_W-1:0] ID_BYTE_LO  = 8'h50;
    localparam logic [BYTE_W-1:0] ID_BYTE_HI  = 8'h43;
    localparam logic [BYTE_W-1:0] TX_OK_CODE  = 8'h01;
    localparam logic [BYTE_W-1:0] STATUS_INIT = 8'h80;

    // Command bit positions
    localparam int CMD_STOP = 0;
    localparam int CMD_TX   = 2;
    localparam int CMD_RRD  = 3;
    localparam int CMD_RWR  = 4;

    // Status bit positions
    localparam int ST_TX   = 1;
    localparam int ST_DMA  = 6;
    localparam int ST_RST  = 7;
endpackage

// File: rtl/nic_cmd_reg.sv
// Command register with its write side effects: transmit kick with
// self-clearing bit, zero-length remote-DMA completion, release of the
// reset-complete flag. Assumes cmd_we is only high for offset 0.
module nic_cmd_reg
    import nic_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              dma_len_zero,
    output logic [BYTE_W-1:0] cmd_q,
    output logic [BYTE_W-1:0] tsr_q,
    output logic              go_pulse,
    output logic              tx_set,
    output logic              dma_set
);
    logic [BYTE_W-1:0] tx_clr_mask;

    // Side-effect decode of a command write
    always_comb begin
        go_pulse    = cmd_we && !wdata[CMD_STOP];
        tx_set      = go_pulse && wdata[CMD_TX];
        dma_set     = go_pulse && (wdata[CMD_RRD] || wdata[CMD_RWR]) && dma_len_zero;
        tx_clr_mask = '1;
        tx_clr_mask[CMD_TX] = !tx_set;
    end

    // Stored command value and transmit status
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
            tsr_q <= '0;
        end else if (cmd_we) begin
            cmd_q <= wdata & tx_clr_mask;
            if (tx_set) begin
                tsr_q <= TX_OK_CODE;
            end
        end
    end

    AST_TX_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && !wdata[CMD_STOP] && wdata[CMD_TX]) |=> (!cmd_q[CMD_TX] && tsr_q == TX_OK_CODE)); // R5
    AST_CMD_STOPPED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && wdata[CMD_STOP]) |=> (cmd_q == $past(wdata))); // R1
endmodule

// File: rtl/nic_isr_ctrl.sv
// Interrupt status and level interrupt. Bits 0..6 are set by engine events
// or command side effects and cleared by host write-one; set wins over clear.
// Bit 7 is the reset-complete flag, released by a running command write.
module nic_isr_ctrl
    import nic_regs_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_we,
    input  logic [IRQ_SRC-1:0] clr_data,
    input  logic [IRQ_SRC-1:0] ev_set,
    input  logic [IRQ_SRC-1:0] int_set,
    input  logic               go_pulse,
    input  logic [IRQ_SRC-1:0] imr,
    output logic [BYTE_W-1:0]  isr_q,
    output logic               irq
);
    logic [IRQ_SRC-1:0] clr_mask;
    logic [IRQ_SRC-1:0] src_next;

    // Next value of the event-driven status bits
    always_comb begin
        clr_mask = clr_we ? clr_data : '0;
        src_next = (isr_q[IRQ_SRC-1:0] & ~clr_mask) | ev_set | int_set;
    end

    // Status register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr_q <= STATUS_INIT;
        end else begin
            isr_q[IRQ_SRC-1:0] <= src_next;
            if (go_pulse) begin
                isr_q[ST_RST] <= 1'b0;
            end
        end
    end

    // Level interrupt from masked sources
    always_comb begin
        irq = |(isr_q[IRQ_SRC-1:0] & imr);
    end

    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_set) |=> ((isr_q[IRQ_SRC-1:0] & $past(ev_set)) == $past(ev_set))); // R10
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && ev_set == '0 && int_set == '0) |=> ((isr_q[IRQ_SRC-1:0] & $past(clr_data)) == '0)); // R2
    AST_TOP_BIT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && !go_pulse) |=> (isr_q[ST_RST] == $past(isr_q[ST_RST]))); // R2
    AST_GO_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        go_pulse |=> !isr_q[ST_RST]); // R3
    AST_DMA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        int_set[ST_DMA] |=> isr_q[ST_DMA]); // R4
    AST_TOP_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (isr_q[IRQ_SRC-1:0] == '0) |-> !irq); // R2
endmodule

// File: rtl/nic_reg_bank.sv
// Page-decoded writable registers: ring pointers, transmit and DMA fields,
// configuration bytes, mask, station address and multicast filter.
// Assumes we is high only for offsets 1..15 and page comes from the
// command value held before this write.
module nic_reg_bank
    import nic_regs_pkg::*;
#(
    parameter int STA_BYTES = 6,
    parameter int MC_BYTES  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  page_e                      page,
    input  logic [OFF_W-1:0]           off,
    input  logic [BYTE_W-1:0]          wdata,
    output logic [BYTE_W-1:0]          ring_start,
    output logic [BYTE_W-1:0]          ring_stop,
    output logic [BYTE_W-1:0]          ring_bound,
    output logic [BYTE_W-1:0]          ring_cur,
    output logic [BYTE_W-1:0]          tx_page,
    output logic [2*BYTE_W-1:0]        tx_len,
    output logic [2*BYTE_W-1:0]        dma_addr,
    output logic [2*BYTE_W-1:0]        dma_len,
    output logic [BYTE_W-1:0]          rx_cfg,
    output logic [BYTE_W-1:0]          data_cfg,
    output logic [IRQ_SRC-1:0]         imr,
    output logic                       status_clr_we,
    output logic [STA_BYTES*BYTE_W-1:0] station_addr,
    output logic [MC_BYTES*BYTE_W-1:0]  mcast_filter
);
    logic we0, we1;

    // Per-page write enables
    always_comb begin
        we0 = we && (page == PG_0);
        we1 = we && (page == PG_1);
        status_clr_we = we0 && (off == OFF_STATUS);
    end

    // Page-0 scalar registers and split 16-bit fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ring_start <= '0;
            ring_stop  <= '0;
            ring_bound <= '0;
            tx_page    <= '0;
            tx_len     <= '0;
            dma_addr   <= '0;
            dma_len    <= '0;
            rx_cfg     <= '0;
            data_cfg   <= '0;
            imr        <= '0;
        end else if (we0) begin
            case (off)
                OFF_RING_LO: ring_start <= wdata;
                OFF_RING_HI: ring_stop  <= wdata;
                OFF_BOUND:   ring_bound <= wdata;
                OFF_TX_PAGE: tx_page    <= wdata;
                OFF_TXLEN_L: tx_len[BYTE_W-1:0]          <= wdata;
                OFF_TXLEN_H: tx_len[2*BYTE_W-1:BYTE_W]   <= wdata;
                OFF_DADDR_L: dma_addr[BYTE_W-1:0]        <= wdata;
                OFF_DADDR_H: dma_addr[2*BYTE_W-1:BYTE_W] <= wdata;
                OFF_DLEN_L:  dma_len[BYTE_W-1:0]         <= wdata;
                OFF_DLEN_H:  dma_len[2*BYTE_W-1:BYTE_W]  <= wdata;
                OFF_RXCFG:   rx_cfg   <= wdata;
                OFF_DCFG:    data_cfg <= wdata;
                OFF_MASK:    imr      <= wdata[IRQ_SRC-1:0];
                default: ;
            endcase
        end
    end

    // Current page register on page 1
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ring_cur <= '0;
        end else if (we1 && off == OFF_CUR) begin
            ring_cur <= wdata;
        end
    end

    // Station address bytes, one register per offset
    for (genvar g = 0; g < STA_BYTES; g++) begin : g_sta
        localparam logic [OFF_W-1:0] MY_OFF = OFF_W'(int'(OFF_STA) + g);
        // Load this station byte
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                station_addr[g*BYTE_W +: BYTE_W] <= '0;
            end else if (we1 && off == MY_OFF) begin
                station_addr[g*BYTE_W +: BYTE_W] <= wdata;
            end
        end
    end

    // Multicast filter bytes, one register per offset
    for (genvar g = 0; g < MC_BYTES; g++) begin : g_mc
        localparam logic [OFF_W-1:0] MY_OFF = OFF_W'(int'(OFF_MC) + g);
        // Load this filter byte
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mcast_filter[g*BYTE_W +: BYTE_W] <= '0;
            end else if (we1 && off == MY_OFF) begin
                mcast_filter[g*BYTE_W +: BYTE_W] <= wdata;
            end
        end
    end

    AST_HALF_KEEP_TX: assert property (@(posedge clk) disable iff (!rst_n)
        (we0 && off == OFF_TXLEN_L) |=> (tx_len[2*BYTE_W-1:BYTE_W] == $past(tx_len[2*BYTE_W-1:BYTE_W]))); // R8
    AST_HALF_KEEP_DMA: assert property (@(posedge clk) disable iff (!rst_n)
        (we0 && off == OFF_DLEN_H) |=> (dma_len[BYTE_W-1:0] == $past(dma_len[BYTE_W-1:0]))); // R8
    AST_PAGE3_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (we && page == PG_3) |=> (ring_start == $past(ring_start) && ring_stop == $past(ring_stop)
                                  && station_addr == $past(station_addr) && imr == $past(imr))); // R1
endmodule

// File: rtl/nic_read_mux.sv
// Host read path: selects the register seen at the current page/offset and
// registers it on a read strobe. Write-only and undefined places read zero.
module nic_read_mux
    import nic_regs_pkg::*;
#(
    parameter int STA_BYTES = 6,
    parameter int MC_BYTES  = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rd,
    input  page_e                       page,
    input  logic [OFF_W-1:0]            off,
    input  logic [BYTE_W-1:0]           cmd_q,
    input  logic [BYTE_W-1:0]           tsr_q,
    input  logic [BYTE_W-1:0]           isr_q,
    input  logic [BYTE_W-1:0]           ring_start,
    input  logic [BYTE_W-1:0]           ring_stop,
    input  logic [BYTE_W-1:0]           ring_bound,
    input  logic [BYTE_W-1:0]           ring_cur,
    input  logic [2*BYTE_W-1:0]         dma_addr,
    input  logic [STA_BYTES*BYTE_W-1:0] station_addr,
    input  logic [MC_BYTES*BYTE_W-1:0]  mcast_filter,
    output logic [BYTE_W-1:0]           rdata
);
    logic [BYTE_W-1:0] sel;
    int                sta_idx;
    int                mc_idx;

    // Combinational register select
    always_comb begin
        sta_idx = int'(off) - int'(OFF_STA);
        mc_idx  = int'(off) - int'(OFF_MC);
        sel     = '0;
        if (off == OFF_CMD) begin
            sel = cmd_q;
        end else begin
            case (page)
                PG_0: begin
                    case (off)
                        OFF_BOUND:   sel = ring_bound;
                        OFF_TX_PAGE: sel = tsr_q;
                        OFF_STATUS:  sel = isr_q;
                        OFF_DADDR_L: sel = dma_addr[BYTE_W-1:0];
                        OFF_DADDR_H: sel = dma_addr[2*BYTE_W-1:BYTE_W];
                        OFF_DLEN_L:  sel = ID_BYTE_LO;
                        OFF_DLEN_H:  sel = ID_BYTE_HI;
                        default:     sel = '0;
                    endcase
                end
                PG_1: begin
                    if (off == OFF_CUR) begin
                        sel = ring_cur;
                    end else if (sta_idx >= 0 && sta_idx < STA_BYTES) begin
                        sel = station_addr[sta_idx*BYTE_W +: BYTE_W];
                    end else if (mc_idx >= 0 && mc_idx < MC_BYTES) begin
                        sel = mcast_filter[mc_idx*BYTE_W +: BYTE_W];
                    end
                end
                PG_2: begin
                    if (off == OFF_RING_LO) begin
                        sel = ring_start;
                    end else if (off == OFF_RING_HI) begin
                        sel = ring_stop;
                    end
                end
                default: sel = '0;
            endcase
        end
    end

    // Capture read data on the strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd) begin
            rdata <= sel;
        end
    end

    AST_ID_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && page == PG_0 && off == OFF_DLEN_L) |=> (rdata == ID_BYTE_LO)); // R9
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(rdata)); // R11
    AST_PAGE3_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && page == PG_3 && off != OFF_CMD) |=> (rdata == '0)); // R1
endmodule

// File: rtl/nic_page_regs.sv
// Top: paged host register file of a simple Ethernet controller. Offset 0
// is the command register; its bits [7:6] pick the page for offsets 1..15.
// Assumes one host access per cycle; engine events arrive as pulses.
module nic_page_regs
    import nic_regs_pkg::*;
#(
    parameter int STA_BYTES = 6,
    parameter int MC_BYTES  = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        host_wr,
    input  logic                        host_rd,
    input  logic [OFF_W-1:0]            host_addr,
    input  logic [BYTE_W-1:0]           host_wdata,
    output logic [BYTE_W-1:0]           host_rdata,
    input  logic [IRQ_SRC-1:0]          ev_set,
    output logic                        irq,
    output logic [BYTE_W-1:0]           cmd_value,
    output logic [BYTE_W-1:0]           ring_start,
    output logic [BYTE_W-1:0]           ring_stop,
    output logic [BYTE_W-1:0]           ring_bound,
    output logic [BYTE_W-1:0]           ring_cur,
    output logic [BYTE_W-1:0]           tx_page,
    output logic [2*BYTE_W-1:0]         tx_len,
    output logic [2*BYTE_W-1:0]         dma_addr,
    output logic [2*BYTE_W-1:0]         dma_len,
    output logic [BYTE_W-1:0]           rx_cfg,
    output logic [BYTE_W-1:0]           data_cfg,
    output logic [STA_BYTES*BYTE_W-1:0] station_addr,
    output logic [MC_BYTES*BYTE_W-1:0]  mcast_filter
);
    logic [BYTE_W-1:0]  cmd_q, tsr_q, isr_q;
    logic               cmd_we, reg_we, go_pulse, tx_set, dma_set, status_clr_we;
    logic [IRQ_SRC-1:0] imr, int_set;
    page_e              page;

    // Offset split between command and paged registers
    always_comb begin
        cmd_we  = host_wr && (host_addr == OFF_CMD);
        reg_we  = host_wr && (host_addr != OFF_CMD);
        page    = page_e'(cmd_q[BYTE_W-1:BYTE_W-2]);
        int_set = '0;
        int_set[ST_TX]  = tx_set;
        int_set[ST_DMA] = dma_set;
        cmd_value = cmd_q;
    end

    nic_cmd_reg cmd_i (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .wdata(host_wdata),
        .dma_len_zero(dma_len == '0), .cmd_q(cmd_q), .tsr_q(tsr_q),
        .go_pulse(go_pulse), .tx_set(tx_set), .dma_set(dma_set)
    );

    nic_isr_ctrl isr_i (
        .clk(clk), .rst_n(rst_n), .clr_we(status_clr_we),
        .clr_data(host_wdata[IRQ_SRC-1:0]), .ev_set(ev_set), .int_set(int_set),
        .go_pulse(go_pulse), .imr(imr), .isr_q(isr_q), .irq(irq)
    );

    nic_reg_bank #(.STA_BYTES(STA_BYTES), .MC_BYTES(MC_BYTES)) bank_i (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .page(page), .off(host_addr),
        .wdata(host_wdata), .ring_start(ring_start), .ring_stop(ring_stop),
        .ring_bound(ring_bound), .ring_cur(ring_cur), .tx_page(tx_page),
        .tx_len(tx_len), .dma_addr(dma_addr), .dma_len(dma_len),
        .rx_cfg(rx_cfg), .data_cfg(data_cfg), .imr(imr),
        .status_clr_we(status_clr_we), .station_addr(station_addr),
        .mcast_filter(mcast_filter)
    );

    nic_read_mux #(.STA_BYTES(STA_BYTES), .MC_BYTES(MC_BYTES)) rmux_i (
        .clk(clk), .rst_n(rst_n), .rd(host_rd), .page(page), .off(host_addr),
        .cmd_q(cmd_q), .tsr_q(tsr_q), .isr_q(isr_q), .ring_start(ring_start),
        .ring_stop(ring_stop), .ring_bound(ring_bound), .ring_cur(ring_cur),
        .dma_addr(dma_addr), .station_addr(station_addr),
        .mcast_filter(mcast_filter), .rdata(host_rdata)
    );

    AST_ZERO_LEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && !host_wdata[CMD_STOP] && (host_wdata[CMD_RRD] || host_wdata[CMD_RWR])
         && dma_len == '0) |=> isr_q[ST_DMA]); // R4
    AST_TX_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && !host_wdata[CMD_STOP] && host_wdata[CMD_TX]) |=> isr_q[ST_TX]); // R5
endmodule

// File: tb/nic_page_regs_tb.sv
module nic_page_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [3:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic [6:0]  ev_set = '0;
    logic        irq;
    logic [7:0]  cmd_value, ring_start, ring_stop, ring_bound, ring_cur, tx_page, rx_cfg, data_cfg;
    logic [15:0] tx_len, dma_addr, dma_len;
    logic [47:0] station_addr;
    logic [63:0] mcast_filter;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [7:0] p1 [16];
    logic [7:0] m_isr, m_imr;

    always #10 clk = ~clk;  // 50 MHz

    nic_page_regs dut_i (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .ev_set(ev_set), .irq(irq), .cmd_value(cmd_value), .ring_start(ring_start),
        .ring_stop(ring_stop), .ring_bound(ring_bound), .ring_cur(ring_cur),
        .tx_page(tx_page), .tx_len(tx_len), .dma_addr(dma_addr), .dma_len(dma_len),
        .rx_cfg(rx_cfg), .data_cfg(data_cfg), .station_addr(station_addr),
        .mcast_filter(mcast_filter)
    );

    function automatic logic exp_irq(logic [7:0] st, logic [7:0] mk);
        return |(st[6:0] & mk[6:0]);
    endfunction

    function automatic logic [7:0] exp_status(logic [7:0] st, logic [6:0] ev, logic [6:0] clr);
        return {st[7], (st[6:0] & ~clr) | ev};
    endfunction

    task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [7:0] v);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        @(negedge clk);
        host_rd = 1'b0;
        v = host_rdata;
    endtask

    task automatic pulse(logic [6:0] e);
        @(negedge clk);
        ev_set = e;
        @(negedge clk);
        ev_set = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R11 watchdog got timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'h5EED_0042));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R3: reset state
        rd(4'd0, v); chk("R3 cmd after reset", v, 8'h00);
        rd(4'd7, v); chk("R3 status after reset", v, 8'h80);
        chk("R3 irq after reset", irq, 1'b0);
        // R2: bit 7 survives write-one clear and never interrupts
        wr(4'd7, 8'hFF); rd(4'd7, v); chk("R2 bit7 kept by clear", v, 8'h80);
        wr(4'd15, 8'hFF); @(negedge clk); chk("R2 bit7 no irq", irq, 1'b0);
        wr(4'd15, 8'h00);
        // R3: stop-set command keeps bit 7, running command clears it
        wr(4'd0, 8'h21); rd(4'd7, v); chk("R3 stop keeps bit7", v, 8'h80);
        wr(4'd0, 8'h22); rd(4'd7, v); chk("R3 go clears bit7", v, 8'h00);
        // R4: zero-length remote read completes at once
        wr(4'd0, 8'h0A); rd(4'd7, v); chk("R4 zero len done", v, 8'h40);
        wr(4'd7, 8'h40); rd(4'd7, v); chk("R2 clear bit6", v, 8'h00);
        wr(4'd10, 8'h05); wr(4'd0, 8'h12); rd(4'd7, v); chk("R4 nonzero len no done", v, 8'h00);
        // R5: transmit kick
        wr(4'd0, 8'h26); rd(4'd0, v); chk("R5 tx bit self clears", v, 8'h22);
        rd(4'd4, v); chk("R5 tx status", v, 8'h01);
        rd(4'd7, v); chk("R5 status tx bit", v, 8'h02);
        wr(4'd7, 8'h02);
        wr(4'd0, 8'h05); rd(4'd0, v); chk("R5 stopped tx kept", v, 8'h05);
        rd(4'd7, v); chk("R5 stopped no status", v, 8'h00);
        wr(4'd0, 8'h22);
        // R6: ring pages
        wr(4'd1, 8'h46); wr(4'd2, 8'h80); wr(4'd3, 8'h4C);
        rd(4'd1, v); chk("R6 page0 start reads zero", v, 8'h00);
        rd(4'd3, v); chk("R6 boundary", v, 8'h4C);
        chk("R6 start port", ring_start, 8'h46);
        wr(4'd0, 8'hA2);
        rd(4'd1, v); chk("R6 page2 start", v, 8'h46);
        rd(4'd2, v); chk("R6 page2 stop", v, 8'h80);
        // R1: page 3 ignores writes and reads zero
        wr(4'd0, 8'hE2); wr(4'd1, 8'h11); wr(4'd15, 8'h7F);
        rd(4'd1, v); chk("R1 page3 reads zero", v, 8'h00);
        chk("R1 page3 write ignored", ring_start, 8'h46);
        rd(4'd0, v); chk("R1 cmd readback", v, 8'hE2);
        wr(4'd0, 8'h22);
        // R8: split 16-bit fields
        wr(4'd5, 8'h34); wr(4'd6, 8'h12); chk("R8 tx len", tx_len, 16'h1234);
        wr(4'd5, 8'h99); chk("R8 tx len low only", tx_len, 16'h1299);
        wr(4'd8, 8'hCD); wr(4'd9, 8'hAB);
        rd(4'd8, v); chk("R8 dma addr lo", v, 8'hCD);
        rd(4'd9, v); chk("R8 dma addr hi", v, 8'hAB);
        wr(4'd10, 8'h78); wr(4'd11, 8'h56); chk("R8 dma len", dma_len, 16'h5678);
        // R9: id bytes and undefined reads
        rd(4'd10, v); chk("R9 id low", v, 8'h50);
        rd(4'd11, v); chk("R9 id high", v, 8'h43);
        // R12: write-only configuration
        wr(4'd4, 8'h40); chk("R12 tx page", tx_page, 8'h40);
        rd(4'd4, v); chk("R12 offset4 reads tx status", v, 8'h01);
        wr(4'd12, 8'h0C); wr(4'd14, 8'h49);
        chk("R12 rx cfg", rx_cfg, 8'h0C); chk("R12 data cfg", data_cfg, 8'h49);
        rd(4'd12, v); chk("R9 offset12 reads zero", v, 8'h00);
        rd(4'd14, v); chk("R9 offset14 reads zero", v, 8'h00);
        // R11: read data holds without strobe
        rd(4'd3, v); wr(4'd3, 8'h99); @(negedge clk);
        chk("R11 rdata held", host_rdata, 8'h4C);

        // R2, R10: directed interrupt sequence
        m_imr = 8'h05; wr(4'd15, m_imr);
        pulse(7'h02); chk("R10 event sets bit1 masked", irq, 1'b0);
        pulse(7'h01); chk("R2 irq on masked source", irq, 1'b1);
        wr(4'd7, 8'h01); chk("R2 irq drops after clear", irq, 1'b0);
        @(negedge clk);
        host_wr = 1'b1; host_addr = 4'd7; host_wdata = 8'h0F; ev_set = 7'h08;
        @(negedge clk);
        host_wr = 1'b0; ev_set = '0;
        rd(4'd7, v); chk("R10 set wins over clear", v, 8'h08);
        m_isr = 8'h08;

        // R10, R2: random event and clear mixes
        for (int i = 0; i < 300; i++) begin
            logic [6:0] e, c;
            logic cw;
            e  = 7'($urandom) & 7'($urandom);
            cw = 1'($urandom);
            c  = cw ? 7'($urandom) : 7'h00;
            if (($urandom % 8) == 0) begin
                m_imr = {1'b0, 7'($urandom)};
                wr(4'd15, m_imr);
            end
            @(negedge clk);
            ev_set = e; host_wr = cw; host_addr = 4'd7; host_wdata = {1'b0, c};
            @(negedge clk);
            ev_set = '0; host_wr = 1'b0;
            m_isr = exp_status(m_isr, e, c);
            chk("R10 random status irq", irq, exp_irq(m_isr, m_imr));
            rd(4'd7, v); chk("R10 random status", v, m_isr);
        end

        // R7: random page-1 accesses against model
        wr(4'd0, 8'h42);
        for (int k = 0; k < 16; k++) p1[k] = 8'h00;
        for (int i = 0; i < 400; i++) begin
            logic [3:0] a;
            logic [7:0] d;
            a = 4'(1 + ($urandom % 15));
            if (1'($urandom)) begin
                d = 8'($urandom); wr(a, d); p1[a] = d;
            end else begin
                rd(a, v); chk("R7 page1 readback", v, p1[a]);
            end
        end
        for (int k = 1; k <= 15; k++) begin
            wr(4'(k), 8'(k * 17 + 3)); p1[k] = 8'(k * 17 + 3);
        end
        begin
            logic [47:0] es;
            logic [63:0] em;
            for (int k = 0; k < 6; k++) es[k*8 +: 8] = p1[k+1];
            for (int k = 0; k < 8; k++) em[k*8 +: 8] = p1[k+8];
            chk("R7 station port", station_addr, es);
            chk("R7 mcast port", mcast_filter, em);
            chk("R7 current page port", ring_cur, p1[7]);
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule